// File: doc/BRIEF.md
# Memory Card SPI-Mode Bring-Up Sequencer

This block takes a memory card from power-up to the point where it can move data in SPI mode. A pulse on `start` begins a run. The sequencer first sends a train of idle bytes with chip select forced high, on the slow clock. It then resets the card into SPI mode. It probes the card's interface condition to tell an older card from a newer one. It then polls the card's operating-condition command until the card leaves its idle state. Last, it fixes the transfer block length at 512 bytes.

The sequencer does not shift bits itself. It hands one request at a time to a separate command engine, using a valid/ready handshake. A request carries a command index and a 32-bit argument. A request can also be a single dummy all-ones byte. For each command, the engine returns the card's 8-bit R1 status byte or a timeout flag.

When a run ends, `done` rises and stays high until the next `start`. At that point `fail`, `card_type` and `byte_addr` give the result. `byte_addr` tells the data path whether block numbers must be scaled by 512 (byte addressing) or used as they are (block addressing). `fast_clk` switches the link to the fast rate only after a run succeeds.

Top module: `sdinit_seq`

## Requirements
- R1: After `start`, exactly WAKE_BYTES dummy requests (`req_dummy`=1, one all-ones byte each) are accepted before any command. `cs_hold`=1 and `fast_clk`=0 while they are pending, and `cs_hold`=0 while a command is pending. Every request keeps `req_valid` and its fields unchanged until `req_ready`.
- R2: The first command is index 0 with argument 0. A reply other than 0x01, or a timeout, ends the run failed, and no further command is issued.
- R3: The second command is index 8 with argument 0x000001AA. A reply of 0x01 selects the newer-card path, and 0x05 selects the older-card path. Any other reply, or a timeout, ends the run failed.
- R4: On the older-card path, the pair index 55 (argument 0) then index 41 (argument 0) repeats until index 41 returns 0x00. The result is then byte addressing (`byte_addr`=1, `card_type`=1).
- R5: On the newer-card path, each attempt first waits at least DELAY_CYCLES cycles. It then issues index 58, index 55, and index 41 with argument 0x40000000. When index 41 returns 0x00, index 58 is issued once more, and the result is block addressing (`byte_addr`=0, `card_type`=2).
- R6: If MAX_TRIES index-41 attempts pass without a 0x00 reply, the run ends failed after exactly MAX_TRIES such commands. A timeout on index 41 counts as an unsuccessful attempt.
- R7: After the card leaves idle, index 16 with argument 512 is issued. A reply of 0x00 ends the run successfully with `fast_clk`=1. Any other reply, or a timeout, ends it failed with `fast_clk`=0.
- R8: The replies to index 55 and index 58 have no effect on the command sequence or the result.
- R9: `done`, `fail`, `card_type` and `byte_addr` hold their values after a run until the next `start`. That `start` drops `done` on the following edge. A `start` during a run is ignored.
- R10: `card_type` uses 0 = failed, 1 = older card with byte addressing, and 2 = newer card with block addressing. It reads 0 whenever `done` is low, and 0 after a failed run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle or finished |
| req_valid | output | 1 | Request to the command engine pending |
| req_ready | input | 1 | Command engine accepts the request |
| req_dummy | output | 1 | Request is one all-ones byte with chip select high, no reply |
| req_idx | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| resp_valid | input | 1 | Reply for the accepted command is present |
| resp_r1 | input | 8 | R1 status byte |
| resp_timeout | input | 1 | Card gave no reply; qualifies resp_valid |
| cs_hold | output | 1 | Keep chip select deasserted (wake phase) |
| fast_clk | output | 1 | Select the fast link clock |
| done | output | 1 | Run finished (sticky) |
| fail | output | 1 | Finished run failed (sticky) |
| card_type | output | 2 | Detected card kind, valid with done |
| byte_addr | output | 1 | 1: scale block numbers by 512; 0: use directly |

## Verification
The bench builds the block with MAX_TRIES = 4 and DELAY_CYCLES = 3, and keeps WAKE_BYTES at 16. With four attempts, the give-up path on both card paths runs within a few hundred cycles. The short pause keeps the newer-card loop quick, while still letting the bench measure the gap between an unsuccessful attempt and the next status read. The bench's card model can stall the operating-condition poll for any number of attempts, return any byte for any command, or time out on a chosen index.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAKE,
        ST_RESET,
        ST_IFCOND,
        ST_V1_APP,
        ST_V1_OPCOND,
        ST_V2_PAUSE,
        ST_V2_OCR,
        ST_V2_APP,
        ST_V2_OPCOND,
        ST_V2_OCR_LAST,
        ST_BLKLEN,
        ST_END
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_V1   = 2'd1,
        KIND_V2   = 2'd2
    } card_kind_e;

    typedef struct packed {
        logic        dummy;
        logic [5:0]  idx;
        logic [31:0] arg;
    } cmd_req_t;

    localparam logic [5:0]  IDX_GO_IDLE  = 6'd0;
    localparam logic [5:0]  IDX_IF_COND  = 6'd8;
    localparam logic [5:0]  IDX_BLK_LEN  = 6'd16;
    localparam logic [5:0]  IDX_OP_COND  = 6'd41;
    localparam logic [5:0]  IDX_APP      = 6'd55;
    localparam logic [5:0]  IDX_READ_OCR = 6'd58;

    localparam logic [31:0] ARG_IF_COND  = 32'h0000_01AA;
    localparam logic [31:0] ARG_HCS      = 32'h4000_0000;
    localparam logic [31:0] ARG_BLK_512  = 32'd512;

    localparam logic [7:0]  R1_READY     = 8'h00;
    localparam logic [7:0]  R1_IDLE      = 8'h01;
    localparam logic [7:0]  R1_IDLE_ILL  = 8'h05;

    function automatic cmd_req_t make_cmd(input logic [5:0] idx, input logic [31:0] arg);
        cmd_req_t r;
        r.dummy = 1'b0;
        r.idx   = idx;
        r.arg   = arg;
        return r;
    endfunction

    function automatic cmd_req_t make_dummy();
        cmd_req_t r;
        r.dummy = 1'b1;
        r.idx   = '0;
        r.arg   = '1;
        return r;
    endfunction

endpackage

// File: rtl/sdinit_countdown.sv
module sdinit_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdinit_attempts.sv
module sdinit_attempts #(
    parameter int MAX_TRIES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump,
    output logic last
);
    localparam int W = $clog2(MAX_TRIES + 2);
    localparam logic [W-1:0] LAST_VAL = W'(MAX_TRIES - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/sdinit_req_slot.sv
module sdinit_req_slot
    import sdinit_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  cmd_req_t load_req,
    input  logic     ready,
    output logic     valid,
    output cmd_req_t held,
    output logic     accepted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            held  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            held  <= load_req;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    assign accepted = valid && ready;
endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
    import sdinit_pkg::*;
#(
    parameter int WAKE_BYTES   = 16,
    parameter int MAX_TRIES    = 5000,
    parameter int DELAY_CYCLES = 2_500_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        req_valid,
    input  logic        req_ready,
    output logic        req_dummy,
    output logic [5:0]  req_idx,
    output logic [31:0] req_arg,
    input  logic        resp_valid,
    input  logic [7:0]  resp_r1,
    input  logic        resp_timeout,
    output logic        cs_hold,
    output logic        fast_clk,
    output logic        done,
    output logic        fail,
    output logic [1:0]  card_type,
    output logic        byte_addr
);
    localparam int WAKE_W = $clog2(WAKE_BYTES + 2);
    localparam int DLY_W  = $clog2(DELAY_CYCLES + 2);

    seq_state_e state_q, state_d;
    card_kind_e kind_q, kind_d;
    logic       sent_q, sent_d;
    logic       done_q, fail_q, fast_q, baddr_q, baddr_d;

    logic       want;
    cmd_req_t   pick;
    cmd_req_t   slot_req;
    logic       slot_valid, accepted;

    logic wake_load, wake_dec, wake_zero;
    logic pause_load, pause_dec, pause_zero;
    logic tries_clr, tries_bump, tries_last;
    logic launch, go_ok, go_fail;
    logic rsp_seen, rsp_ready, rsp_idle;

    assign rsp_seen  = resp_valid && sent_q && !slot_valid;
    assign rsp_ready = !resp_timeout && (resp_r1 == R1_READY);
    assign rsp_idle  = !resp_timeout && (resp_r1 == R1_IDLE);

    sdinit_req_slot u_slot (
        .clk      (clk),
        .rst      (rst),
        .load     (want && !sent_q),
        .load_req (pick),
        .ready    (req_ready),
        .valid    (slot_valid),
        .held     (slot_req),
        .accepted (accepted)
    );

    sdinit_countdown #(.W(WAKE_W)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .load     (wake_load),
        .load_val (WAKE_W'(WAKE_BYTES)),
        .dec      (wake_dec),
        .zero     (wake_zero)
    );

    sdinit_countdown #(.W(DLY_W)) u_pause (
        .clk      (clk),
        .rst      (rst),
        .load     (pause_load),
        .load_val (DLY_W'(DELAY_CYCLES)),
        .dec      (pause_dec),
        .zero     (pause_zero)
    );

    sdinit_attempts #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk  (clk),
        .rst  (rst),
        .clr  (tries_clr),
        .bump (tries_bump),
        .last (tries_last)
    );

    always_comb begin
        state_d    = state_q;
        sent_d     = sent_q;
        kind_d     = kind_q;
        baddr_d    = baddr_q;
        want       = 1'b0;
        pick       = '0;
        wake_load  = 1'b0;
        wake_dec   = 1'b0;
        pause_load = 1'b0;
        pause_dec  = 1'b0;
        tries_clr  = 1'b0;
        tries_bump = 1'b0;
        launch     = 1'b0;
        go_ok      = 1'b0;
        go_fail    = 1'b0;

        case (state_q)
            ST_IDLE, ST_END: begin
                if (start) begin
                    launch    = 1'b1;
                    wake_load = 1'b1;
                    sent_d    = 1'b0;
                    kind_d    = KIND_NONE;
                    state_d   = ST_WAKE;
                end
            end
            ST_WAKE: begin
                pick = make_dummy();
                if (accepted) begin
                    wake_dec = 1'b1;
                    sent_d   = 1'b0;
                end else if (!sent_q) begin
                    if (wake_zero) state_d = ST_RESET;
                    else           want    = 1'b1;
                end
            end
            ST_RESET: begin
                pick = make_cmd(IDX_GO_IDLE, '0);
                want = 1'b1;
                if (rsp_seen) begin
                    sent_d = 1'b0;
                    if (rsp_idle) state_d = ST_IFCOND;
                    else          go_fail = 1'b1;
                end
            end
            ST_IFCOND: begin
                pick = make_cmd(IDX_IF_COND, ARG_IF_COND);
                want = 1'b1;
                if (rsp_seen) begin
                    sent_d    = 1'b0;
                    tries_clr = 1'b1;
                    if (rsp_idle) begin
                        kind_d     = KIND_V2;
                        baddr_d    = 1'b0;
                        pause_load = 1'b1;
                        state_d    = ST_V2_PAUSE;
                    end else if (!resp_timeout && resp_r1 == R1_IDLE_ILL) begin
                        kind_d  = KIND_V1;
                        baddr_d = 1'b1;
                        state_d = ST_V1_APP;
                    end else begin
                        go_fail = 1'b1;
                    end
                end
            end
            ST_V1_APP: begin
                pick = make_cmd(IDX_APP, '0);
                want = 1'b1;
                if (rsp_seen) begin
                    sent_d  = 1'b0;
                    state_d = ST_V1_OPCOND;
                end
            end
            ST_V1_OPCOND: begin
                pick = make_cmd(IDX_OP_COND, '0);
                want = 1'b1;
                if (rsp_seen) begin
                    sent_d = 1'b0;
                    if (rsp_ready)       state_d = ST_BLKLEN;
                    else if (tries_last) go_fail = 1'b1;
                    else begin
                        tries_bump = 1'b1;
                        state_d    = ST_V1_APP;
                    end
                end
            end
            ST_V2_PAUSE: begin
                pause_dec = 1'b1;
                if (pause_zero) state_d = ST_V2_OCR;
            end
            ST_V2_OCR: begin
                pick = make_cmd(IDX_READ_OCR, '0);
                want = 1'b1;
                if (rsp_seen) begin
                    sent_d  = 1'b0;
                    state_d = ST_V2_APP;
                end
            end
            ST_V2_APP: begin
                pick = make_cmd(IDX_APP, '0);
                want = 1'b1;
                if (rsp_seen) begin
                    sent_d  = 1'b0;
                    state_d = ST_V2_OPCOND;
                end
            end
            ST_V2_OPCOND: begin
                pick = make_cmd(IDX_OP_COND, ARG_HCS);
                want = 1'b1;
                if (rsp_seen) begin
                    sent_d = 1'b0;
                    if (rsp_ready)       state_d = ST_V2_OCR_LAST;
                    else if (tries_last) go_fail = 1'b1;
                    else begin
                        tries_bump = 1'b1;
                        pause_load = 1'b1;
                        state_d    = ST_V2_PAUSE;
                    end
                end
            end
            ST_V2_OCR_LAST: begin
                pick = make_cmd(IDX_READ_OCR, '0);
                want = 1'b1;
                if (rsp_seen) begin
                    sent_d  = 1'b0;
                    state_d = ST_BLKLEN;
                end
            end
            ST_BLKLEN: begin
                pick = make_cmd(IDX_BLK_LEN, ARG_BLK_512);
                want = 1'b1;
                if (rsp_seen) begin
                    sent_d = 1'b0;
                    if (rsp_ready) go_ok   = 1'b1;
                    else           go_fail = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (want && !sent_q) sent_d = 1'b1;
        if (go_ok || go_fail) state_d = ST_END;
        if (go_fail) kind_d = KIND_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sent_q  <= 1'b0;
            kind_q  <= KIND_NONE;
            baddr_q <= 1'b0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            fast_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sent_q  <= sent_d;
            kind_q  <= kind_d;
            baddr_q <= baddr_d;
            if (launch) begin
                done_q <= 1'b0;
                fail_q <= 1'b0;
                fast_q <= 1'b0;
            end else if (go_ok) begin
                done_q <= 1'b1;
                fail_q <= 1'b0;
                fast_q <= 1'b1;
            end else if (go_fail) begin
                done_q <= 1'b1;
                fail_q <= 1'b1;
                fast_q <= 1'b0;
            end
        end
    end

    assign req_valid = slot_valid;
    assign req_dummy = slot_req.dummy;
    assign req_idx   = slot_req.idx;
    assign req_arg   = slot_req.arg;
    assign cs_hold   = (state_q == ST_WAKE);
    assign fast_clk  = fast_q;
    assign done      = done_q;
    assign fail      = fail_q;
    assign card_type = done_q ? kind_q : KIND_NONE;
    assign byte_addr = baddr_q;
endmodule

// File: rtl/sdinit_seq_checker.sv
module sdinit_seq_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_dummy,
    input logic [5:0]  req_idx,
    input logic [31:0] req_arg,
    input logic        cs_hold,
    input logic        fast_clk,
    input logic        done,
    input logic        fail,
    input logic [1:0]  card_type,
    input logic        byte_addr
);
    assert_wake_cs_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dummy) |-> (cs_hold && !fast_clk));

    assert_cmd_cs_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_dummy) |-> !cs_hold);

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_dummy)
                                       && $stable(req_idx) && $stable(req_arg)));

    assert_ifcond_arg_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_dummy && req_idx == 6'd8) |-> (req_arg == 32'h0000_01AA));

    assert_opcond_arg_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_dummy && req_idx == 6'd41)
            |-> (req_arg == 32'h0 || req_arg == 32'h4000_0000));

    assert_blklen_arg_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_dummy && req_idx == 6'd16) |-> (req_arg == 32'd512));

    assert_fast_ok_R7: assert property (@(posedge clk) disable iff (rst)
        fast_clk |-> (done && !fail));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail) && $stable(card_type) && $stable(byte_addr)));

    assert_type_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> (card_type == 2'd0));

    assert_fail_type_R10: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (card_type == 2'd0));

    assert_v1_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (done && card_type == 2'd1) |-> byte_addr);

    assert_v2_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (done && card_type == 2'd2) |-> !byte_addr);
endmodule

bind sdinit_seq sdinit_seq_checker u_sdinit_seq_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_dummy (req_dummy),
    .req_idx   (req_idx),
    .req_arg   (req_arg),
    .cs_hold   (cs_hold),
    .fast_clk  (fast_clk),
    .done      (done),
    .fail      (fail),
    .card_type (card_type),
    .byte_addr (byte_addr)
);

// File: tb/test_sdinit_seq.sv
`timescale 1ns/1ps
module test_sdinit_seq;
    localparam int TB_WAKE  = 16;
    localparam int TB_TRIES = 4;
    localparam int TB_DELAY = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        req_valid, req_ready, req_dummy;
    logic [5:0]  req_idx;
    logic [31:0] req_arg;
    logic        resp_valid, resp_timeout;
    logic [7:0]  resp_r1;
    logic        cs_hold, fast_clk, done, fail, byte_addr;
    logic [1:0]  card_type;

    always #4 clk = ~clk;

    sdinit_seq #(
        .WAKE_BYTES  (TB_WAKE),
        .MAX_TRIES   (TB_TRIES),
        .DELAY_CYCLES(TB_DELAY)
    ) i_sdinit_seq (
        .clk(clk), .rst(rst), .start(start),
        .req_valid(req_valid), .req_ready(req_ready), .req_dummy(req_dummy),
        .req_idx(req_idx), .req_arg(req_arg),
        .resp_valid(resp_valid), .resp_r1(resp_r1), .resp_timeout(resp_timeout),
        .cs_hold(cs_hold), .fast_clk(fast_clk), .done(done), .fail(fail),
        .card_type(card_type), .byte_addr(byte_addr)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // card model settings
    logic [7:0] m_cmd0, m_cmd8, m_cmd16, m_junk;
    int         m_busy, m_to_idx, a41_seen;

    // request log
    logic [5:0]  log_idx [0:63];
    logic [31:0] log_arg [0:63];
    int          log_cyc [0:63];
    int          n_log, n_dummy, order_err;
    logic [5:0]  exp_idx [0:63];
    logic [31:0] exp_arg [0:63];
    int          n_exp;

    task automatic check(input string req, input bit ok, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // command engine and card model
    initial begin
        int         pend;
        logic [7:0] pend_r1;
        logic       pend_to;
        pend = 0; pend_r1 = 8'hFF; pend_to = 1'b0;
        req_ready = 1'b0; resp_valid = 1'b0; resp_r1 = 8'hFF; resp_timeout = 1'b0;
        forever begin
            @(negedge clk);
            req_ready = 1'b0; resp_valid = 1'b0; resp_timeout = 1'b0; resp_r1 = 8'hFF;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    resp_valid   = 1'b1;
                    resp_timeout = pend_to;
                    resp_r1      = pend_to ? 8'hFF : pend_r1;
                end
            end else if (req_valid && !rst) begin
                req_ready = 1'b1;
                if (req_dummy) begin
                    n_dummy++;
                    if (!cs_hold || fast_clk || n_log != 0) order_err++;
                end else begin
                    if (n_dummy != TB_WAKE || cs_hold || fast_clk) order_err++;
                    if (n_log < 64) begin
                        log_idx[n_log] = req_idx;
                        log_arg[n_log] = req_arg;
                        log_cyc[n_log] = cyc;
                    end
                    n_log++;
                    pend    = 2;
                    pend_to = (int'(req_idx) == m_to_idx);
                    case (req_idx)
                        6'd0:  pend_r1 = m_cmd0;
                        6'd8:  pend_r1 = m_cmd8;
                        6'd16: pend_r1 = m_cmd16;
                        6'd41: begin
                            pend_r1 = (a41_seen < m_busy) ? 8'h01 : 8'h00;
                            a41_seen++;
                        end
                        default: pend_r1 = m_junk;
                    endcase
                end
            end
        end
    end

    task automatic setup(input logic [7:0] c0, input logic [7:0] c8, input int busy,
                         input logic [7:0] c16, input int to_idx, input logic [7:0] junk);
        m_cmd0 = c0; m_cmd8 = c8; m_busy = busy; m_cmd16 = c16;
        m_to_idx = to_idx; m_junk = junk; a41_seen = 0;
        n_log = 0; n_dummy = 0; order_err = 0; n_exp = 0;
    endtask

    task automatic add(input logic [5:0] idx, input logic [31:0] arg);
        exp_idx[n_exp] = idx;
        exp_arg[n_exp] = arg;
        n_exp++;
    endtask

    task automatic add_v2_try();
        add(6'd58, 32'h0); add(6'd55, 32'h0); add(6'd41, 32'h4000_0000);
    endtask

    task automatic add_v1_try();
        add(6'd55, 32'h0); add(6'd41, 32'h0);
    endtask

    task automatic launch(input bit repulse);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 done cleared by start", done == 1'b0, done, 0);
        check("R10 card_type zero while running", card_type == 2'd0, card_type, 0);
        if (repulse) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
        check("R9 run finished", done == 1'b1, done, 1);
    endtask

    task automatic compare_log(input string req);
        int bad_at;
        bad_at = -1;
        for (int i = 0; i < n_exp && i < n_log; i++)
            if (bad_at < 0 && (log_idx[i] != exp_idx[i] || log_arg[i] != exp_arg[i])) bad_at = i;
        check({req, " command count"}, n_log == n_exp, n_log, n_exp);
        check({req, " command order/args (first bad entry)"}, bad_at < 0, bad_at, -1);
        check("R1 wake byte count", n_dummy == TB_WAKE, n_dummy, TB_WAKE);
        check("R1 chip select / clock during requests", order_err == 0, order_err, 0);
    endtask

    task automatic check_end(input string req, input bit f, input logic [1:0] t,
                             input bit ba, input bit fc);
        check({req, " fail"}, fail == f, fail, f);
        check({req, " card_type"}, card_type == t, card_type, t);
        if (!f) check({req, " byte_addr"}, byte_addr == ba, byte_addr, ba);
        check({req, " fast_clk"}, fast_clk == fc, fast_clk, fc);
    endtask

    task automatic t_reset();
        check("R10 reset done", done == 1'b0, done, 0);
        check("R10 reset fail", fail == 1'b0, fail, 0);
        check("R10 reset card_type", card_type == 2'd0, card_type, 0);
        check("R7 reset fast_clk", fast_clk == 1'b0, fast_clk, 0);
        check("R1 reset req_valid", req_valid == 1'b0, req_valid, 0);
    endtask

    task automatic t_v2_ok();
        int gap;
        setup(8'h01, 8'h01, 2, 8'h00, -1, 8'h7F);
        add(6'd0, 0); add(6'd8, 32'h1AA);
        add_v2_try(); add_v2_try(); add_v2_try(); add(6'd58, 0); add(6'd16, 512);
        launch(1'b0);
        compare_log("R5 R8");
        check_end("R5", 1'b0, 2'd2, 1'b0, 1'b1);
        gap = log_cyc[5] - log_cyc[4];
        check("R5 pause before next attempt", gap >= TB_DELAY + 5, gap, TB_DELAY + 5);
        repeat (25) @(negedge clk);
        check("R9 result held", done && card_type == 2'd2 && fast_clk, card_type, 2);
    endtask

    task automatic t_v1_ok();
        setup(8'h01, 8'h05, 1, 8'h00, -1, 8'h00);
        add(6'd0, 0); add(6'd8, 32'h1AA);
        add_v1_try(); add_v1_try(); add(6'd16, 512);
        launch(1'b0);
        compare_log("R4");
        check_end("R4", 1'b0, 2'd1, 1'b1, 1'b1);
    endtask

    task automatic t_v1_junk_restart();
        setup(8'h01, 8'h05, 0, 8'h00, -1, 8'h7F);
        add(6'd0, 0); add(6'd8, 32'h1AA); add_v1_try(); add(6'd16, 512);
        launch(1'b1);
        compare_log("R8 R9 start ignored mid-run");
        check_end("R8", 1'b0, 2'd1, 1'b1, 1'b1);
    endtask

    task automatic t_v1_give_up();
        setup(8'h01, 8'h05, 1000, 8'h00, -1, 8'h00);
        add(6'd0, 0); add(6'd8, 32'h1AA);
        for (int i = 0; i < TB_TRIES; i++) add_v1_try();
        launch(1'b0);
        compare_log("R6 older path");
        check_end("R6", 1'b1, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_v2_give_up();
        setup(8'h01, 8'h01, 1000, 8'h00, -1, 8'h00);
        add(6'd0, 0); add(6'd8, 32'h1AA);
        for (int i = 0; i < TB_TRIES; i++) add_v2_try();
        launch(1'b0);
        compare_log("R6 newer path");
        check_end("R6", 1'b1, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_v2_timeout_tries();
        setup(8'h01, 8'h01, 0, 8'h00, 41, 8'h00);
        add(6'd0, 0); add(6'd8, 32'h1AA);
        for (int i = 0; i < TB_TRIES; i++) add_v2_try();
        launch(1'b0);
        compare_log("R6 timeout counts as attempt");
        check_end("R6", 1'b1, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_reset_bad(input logic [7:0] r, input int to_idx);
        setup(r, 8'h01, 0, 8'h00, to_idx, 8'h00);
        add(6'd0, 0);
        launch(1'b0);
        compare_log("R2");
        check_end("R2", 1'b1, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_ifcond_bad(input logic [7:0] r, input int to_idx);
        setup(8'h01, r, 0, 8'h00, to_idx, 8'h00);
        add(6'd0, 0); add(6'd8, 32'h1AA);
        launch(1'b0);
        compare_log("R3");
        check_end("R3", 1'b1, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_blklen_bad();
        setup(8'h01, 8'h05, 0, 8'h40, -1, 8'h00);
        add(6'd0, 0); add(6'd8, 32'h1AA); add_v1_try(); add(6'd16, 512);
        launch(1'b0);
        compare_log("R7");
        check_end("R7", 1'b1, 2'd0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_cmd0 = 8'h01; m_cmd8 = 8'h01; m_cmd16 = 8'h00; m_junk = 8'h00;
        m_busy = 0; m_to_idx = -1; a41_seen = 0;
        n_log = 0; n_dummy = 0; order_err = 0; n_exp = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_v2_ok();
        t_v1_ok();
        t_v1_junk_restart();
        t_v1_give_up();
        t_v2_give_up();
        t_v2_timeout_tries();
        t_reset_bad(8'h00, -1);
        t_reset_bad(8'h01, 0);
        t_ifcond_bad(8'h04, -1);
        t_ifcond_bad(8'h01, 8);
        t_blklen_bad();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule